// File: doc/BRIEF.md
# UART Status and Control Register with Parity / Ninth-Bit Handling

This block combines one 8-bit CPU-visible status/control register with a small serial transmitter and receiver. The register shows the receive condition, whether the transmit buffer is empty, the two interrupt enables, and one bit per direction for the ninth frame bit. Software writes a byte to the transmit data port, watches the empty flag and reads received bytes from the receive data port. Mode selection (9-bit frame length, parity on or off) arrives on plain input pins.

The receive condition is held in a four-state machine whose state is the two top register bits. The states are EMPTY (00), FERR (01, bad stop bit or parity mismatch), FULL (10, byte waiting) and OVR (11, a frame ended while a byte was still unread). Its transitions are: frame-done to OVR from FULL or OVR; frame-done to FERR or FULL from EMPTY or FERR; error-clear from FERR to EMPTY and from OVR to FULL; data-read from FULL to EMPTY. The transmitter runs TX_IDLE, TX_START, TX_DATA, TX_NINTH and TX_STOP. The receiver runs RX_IDLE, RX_START (check the line at half a bit), RX_DATA, RX_NINTH, RX_STOP and RX_HOLD (wait for the line to go high after a low stop bit). Each bit lasts CLKS_PER_BIT clocks.

Bit 1 of the register does two jobs. With parity on, it picks the parity sense for both directions (0 odd, 1 even). With parity off and 9-bit frames, it is the ninth transmitted bit. Bit 0 returns the ninth bit of the last frame that was accepted.

Top module: `sio_stat_ctl`

## Requirements
- R1: After reset the register reads 0x22: code 00, bit5 (transmit empty) 1, bit4 and bit3 (enables) 0, bit1 1, bit0 0. Bit2 always reads 0.
- R2: A register write changes only bit4 (transmit interrupt enable), bit3 (receive interrupt enable) and bit1. Written values in bits 7, 6, 5, 2 and 0 are ignored.
- R3: A frame with a high stop bit and, when parity is on, correct parity, received while bit7 is 0, sets code 10. The frame loads the received byte on the receive data port and puts the ninth bit in bit0. In 8-bit frames without parity the ninth bit reads as 0.
- R4: A frame whose stop bit samples low, received while bit7 is 0, sets code 01. Neither the receive data nor bit0 change.
- R5: With parity on, every frame carries a ninth bit that is the parity. With bit1=0 the byte plus parity must hold an odd number of ones, and with bit1=1 an even number. A mismatch, received while bit7 is 0, sets code 01 and loads nothing.
- R6: A frame that completes while bit7 is 1 sets code 11. The receive data keeps the earlier byte.
- R7: A receive data read changes code 10 to 00. It leaves codes 00, 01 and 11 unchanged.
- R8: An error-clear strobe changes code 01 to 00 and code 11 to 10.
- R9: A transmit data write makes bit5 read 0 on the next cycle. Bit5 returns to 1 when the byte moves into the shifter, which happens only once the shifter is idle. A write during a frame therefore keeps bit5 at 0 until that frame has finished.
- R10: Transmit frames are sent in this order, each bit lasting CLKS_PER_BIT clocks: a low start bit, eight data bits LSB first, a ninth bit when 9-bit mode or parity is on, then a high stop bit. The line idles high.
- R11: With parity on, the transmitted ninth bit is the parity chosen by bit1 (rule of R5). Otherwise, in 9-bit mode, it is the value of bit1.
- R12: rx_irq is high exactly when bit3 is 1 and the code is not 00. tx_irq is high exactly when bit4 is 1 and bit5 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_wr | input | 1 | Register write strobe |
| stat_wdata | input | 8 | Register write data |
| stat_rdata | output | 8 | Register read value |
| txd_wr | input | 1 | Transmit data write strobe |
| txd_data | input | 8 | Transmit data byte |
| rxd_rd | input | 1 | Receive data read strobe |
| rxd_data | output | 8 | Last accepted received byte |
| err_clr | input | 1 | Receive error clear strobe |
| nine_bit_mode | input | 1 | 1 selects 9-bit frames |
| parity_on | input | 1 | 1 makes the ninth bit a parity bit |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The hardest condition to reach is the overrun code. Two full frames must finish with no data read between them, and only then may the error clear and the data read be applied, in that order, to walk the state machine 11 to 10 to 00. The bench builds each frame bit by bit on ser_in at CLKS_PER_BIT clocks per bit, with chosen ninth and stop bits. This also produces the parity mismatches and low stop bits. A second hard case is a transmit write while a frame is in flight. The bench writes again right after the first byte leaves the buffer and checks that the empty flag stays low through the whole first frame.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        RXC_EMPTY = 2'b00,
        RXC_FERR  = 2'b01,
        RXC_FULL  = 2'b10,
        RXC_OVR   = 2'b11
    } rxc_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_NINTH,
        TX_STOP
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP,
        RX_HOLD
    } rx_st_e;

    // register bit positions
    localparam int unsigned BIT_RDRF = 7;
    localparam int unsigned BIT_TEMPTY = 5;
    localparam int unsigned BIT_TIE = 4;
    localparam int unsigned BIT_RIE = 3;
    localparam int unsigned BIT_SEL = 1;

    // parity bit for a byte: even=0 gives odd total, even=1 gives even total
    function automatic logic make_parity(input logic [7:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              par_on,
    input  logic              nine_mode,
    input  logic              sel_bit,
    output logic              ser_out,
    output logic              tempty
);

    localparam int unsigned CW = $clog2(CLKS_PER_BIT);
    localparam int unsigned IW = $clog2(DATA_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

    tx_st_e            st, st_nxt;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shreg;
    logic              ninth_q;
    logic              ninth_en_q;
    logic              bit_end;
    logic              load;

    assign bit_end = (cnt == CNT_LAST);
    assign load    = (st == TX_IDLE) && !tempty;

    always_comb begin
        st_nxt = st;
        unique case (st)
            TX_IDLE:  if (!tempty) st_nxt = TX_START;
            TX_START: if (bit_end) st_nxt = TX_DATA;
            TX_DATA:  if (bit_end && idx == IDX_LAST)
                          st_nxt = ninth_en_q ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bit_end) st_nxt = TX_STOP;
            TX_STOP:  if (bit_end) st_nxt = TX_IDLE;
            default:  st_nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            idx        <= '0;
            hold_q     <= '0;
            shreg      <= '0;
            ninth_q    <= 1'b0;
            ninth_en_q <= 1'b0;
            tempty     <= 1'b1;
        end else begin
            if (st == TX_IDLE || bit_end) cnt <= '0;
            else                          cnt <= cnt + 1'b1;

            if (wr) hold_q <= wr_data;

            if (wr)        tempty <= 1'b0;
            else if (load) tempty <= 1'b1;

            if (load) begin
                shreg      <= hold_q;
                idx        <= '0;
                ninth_q    <= par_on ? make_parity(hold_q, sel_bit) : sel_bit;
                ninth_en_q <= par_on | nine_mode;
            end else if (st == TX_DATA && bit_end) begin
                shreg <= shreg >> 1;
                idx   <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (st)
            TX_IDLE:  ser_out = 1'b1;
            TX_START: ser_out = 1'b0;
            TX_DATA:  ser_out = shreg[0];
            TX_NINTH: ser_out = ninth_q;
            TX_STOP:  ser_out = 1'b1;
            default:  ser_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              par_on,
    input  logic              nine_mode,
    input  logic              sel_bit,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ninth,
    output logic              stop_ok,
    output logic              par_err
);

    localparam int unsigned CW = $clog2(CLKS_PER_BIT);
    localparam int unsigned IW = $clog2(DATA_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(CLKS_PER_BIT / 2 - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxs;
    rx_st_e                 st, st_nxt;
    logic [CW-1:0]          cnt;
    logic [IW-1:0]          idx;
    logic [DATA_W-1:0]      shreg;
    logic                   ninth_q;
    logic                   has9_q;
    logic                   bit_end;

    assign rxs     = sync_q[SYNC_STAGES-1];
    assign bit_end = (cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ser_in};
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RX_IDLE:  if (!rxs) st_nxt = RX_START;
            RX_START: if (cnt == CNT_HALF) st_nxt = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && idx == IDX_LAST)
                          st_nxt = has9_q ? RX_NINTH : RX_STOP;
            RX_NINTH: if (bit_end) st_nxt = RX_STOP;
            RX_STOP:  if (bit_end) st_nxt = rxs ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rxs) st_nxt = RX_IDLE;
            default:  st_nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            ninth_q <= 1'b0;
            has9_q  <= 1'b0;
        end else begin
            if (st == RX_IDLE || st == RX_HOLD || st_nxt != st || bit_end) cnt <= '0;
            else                                                            cnt <= cnt + 1'b1;

            if (st == RX_START && st_nxt == RX_DATA) begin
                idx     <= '0;
                ninth_q <= 1'b0;
                has9_q  <= par_on | nine_mode;
            end else if (st == RX_DATA && bit_end) begin
                shreg <= {rxs, shreg[DATA_W-1:1]};
                idx   <= idx + 1'b1;
            end else if (st == RX_NINTH && bit_end) begin
                ninth_q <= rxs;
            end
        end
    end

    // frame result, presented for one cycle after the stop bit sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            data    <= '0;
            ninth   <= 1'b0;
            stop_ok <= 1'b0;
            par_err <= 1'b0;
        end else begin
            done <= (st == RX_STOP) && bit_end;
            if (st == RX_STOP && bit_end) begin
                data    <= shreg;
                ninth   <= ninth_q;
                stop_ok <= rxs;
                par_err <= par_on && ((^{shreg, ninth_q}) == sel_bit);
            end
        end
    end

endmodule

// File: rtl/sio_regs.sv
module sio_regs
    import sio_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [7:0]        stat_wdata,
    input  logic              rxd_rd,
    input  logic              err_clr,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_ninth,
    input  logic              rx_stop_ok,
    input  logic              rx_par_err,
    input  logic              tempty,
    output logic [7:0]        stat_rdata,
    output logic              sel_bit,
    output logic [DATA_W-1:0] rxd_data,
    output logic              rx_irq,
    output logic              tx_irq
);

    rxc_e code, code_nxt;
    logic tie_q;
    logic rie_q;
    logic rd8_q;
    logic good_frame;

    assign good_frame = rx_stop_ok && !rx_par_err;

    always_comb begin
        code_nxt = code;
        if (rx_done) begin
            unique case (code)
                RXC_FULL, RXC_OVR:   code_nxt = RXC_OVR;
                RXC_EMPTY, RXC_FERR: code_nxt = good_frame ? RXC_FULL : RXC_FERR;
                default:             code_nxt = code;
            endcase
        end else if (err_clr) begin
            unique case (code)
                RXC_FERR: code_nxt = RXC_EMPTY;
                RXC_OVR:  code_nxt = RXC_FULL;
                default:  code_nxt = code;
            endcase
        end else if (rxd_rd && code == RXC_FULL) begin
            code_nxt = RXC_EMPTY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code <= RXC_EMPTY;
        else        code <= code_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_data <= '0;
            rd8_q    <= 1'b0;
        end else if (rx_done && !code[1] && good_frame) begin
            rxd_data <= rx_data;
            rd8_q    <= rx_ninth;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tie_q   <= 1'b0;
            rie_q   <= 1'b0;
            sel_bit <= 1'b1;
        end else if (stat_wr) begin
            tie_q   <= stat_wdata[BIT_TIE];
            rie_q   <= stat_wdata[BIT_RIE];
            sel_bit <= stat_wdata[BIT_SEL];
        end
    end

    always_comb begin
        stat_rdata = {code, tempty, tie_q, rie_q, 1'b0, sel_bit, rd8_q};
        rx_irq     = rie_q && (code != RXC_EMPTY);
        tx_irq     = tie_q && tempty;
    end

endmodule

// File: rtl/sio_stat_ctl.sv
module sio_stat_ctl
    import sio_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [7:0]        stat_wdata,
    output logic [7:0]        stat_rdata,
    input  logic              txd_wr,
    input  logic [DATA_W-1:0] txd_data,
    input  logic              rxd_rd,
    output logic [DATA_W-1:0] rxd_data,
    input  logic              err_clr,
    input  logic              nine_bit_mode,
    input  logic              parity_on,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              rx_irq,
    output logic              tx_irq
);

    logic              sel_bit;
    logic              tempty;
    logic              rx_done;
    logic [DATA_W-1:0] rx_data;
    logic              rx_ninth;
    logic              rx_stop_ok;
    logic              rx_par_err;

    sio_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (txd_wr),
        .wr_data   (txd_data),
        .par_on    (parity_on),
        .nine_mode (nine_bit_mode),
        .sel_bit   (sel_bit),
        .ser_out   (ser_out),
        .tempty    (tempty)
    );

    sio_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W), .SYNC_STAGES(2)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .par_on    (parity_on),
        .nine_mode (nine_bit_mode),
        .sel_bit   (sel_bit),
        .done      (rx_done),
        .data      (rx_data),
        .ninth     (rx_ninth),
        .stop_ok   (rx_stop_ok),
        .par_err   (rx_par_err)
    );

    sio_regs #(.DATA_W(DATA_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .rxd_rd     (rxd_rd),
        .err_clr    (err_clr),
        .rx_done    (rx_done),
        .rx_data    (rx_data),
        .rx_ninth   (rx_ninth),
        .rx_stop_ok (rx_stop_ok),
        .rx_par_err (rx_par_err),
        .tempty     (tempty),
        .stat_rdata (stat_rdata),
        .sel_bit    (sel_bit),
        .rxd_data   (rxd_data),
        .rx_irq     (rx_irq),
        .tx_irq     (tx_irq)
    );

endmodule

// File: rtl/sio_stat_chk.sv
module sio_stat_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stat_wr,
    input logic [7:0]        stat_wdata,
    input logic [7:0]        stat_rdata,
    input logic              txd_wr,
    input logic              rxd_rd,
    input logic              err_clr,
    input logic              rx_done,
    input logic [DATA_W-1:0] rxd_data,
    input logic              rx_irq
);

    assert_wr_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (stat_rdata[4:3] == $past(stat_wdata[4:3])) &&
                    (stat_rdata[1] == $past(stat_wdata[1])));

    assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && stat_rdata[7]) |=> (stat_rdata[7:6] == 2'b11) && $stable(rxd_data));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_rd && !rx_done && !err_clr && stat_rdata[7:6] == 2'b10) |=> (stat_rdata[7:6] == 2'b00));

    assert_clear_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !rx_done && stat_rdata[7:6] == 2'b11) |=> (stat_rdata[7:6] == 2'b10));

    assert_tempty_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        txd_wr |=> !stat_rdata[5]);

    assert_rie_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_wdata[3]) |=> !rx_irq);

endmodule

bind sio_stat_ctl sio_stat_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .stat_rdata (stat_rdata),
    .txd_wr     (txd_wr),
    .rxd_rd     (rxd_rd),
    .err_clr    (err_clr),
    .rx_done    (rx_done),
    .rxd_data   (rxd_data),
    .rx_irq     (rx_irq)
);

// File: tb/sio_stat_ctl_tb_top.sv
module sio_stat_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CPB = 8;
    localparam int NVEC = 9;

    // {nine, par, sel, ninth, stop, data[7:0], code[1:0], bit0}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 2'b10, 1'b0},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 2'b01, 1'b0},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 2'b10, 1'b1},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC3, 2'b10, 1'b0},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h03, 2'b10, 1'b1},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h03, 2'b01, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h07, 2'b10, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h07, 2'b01, 1'b1},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 2'b01, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic [7:0] stat_rdata;
    logic       txd_wr = 1'b0;
    logic [7:0] txd_data = '0;
    logic       rxd_rd = 1'b0;
    logic [7:0] rxd_data;
    logic       err_clr = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       parity_on = 1'b0;
    logic       ser_in = 1'b1;
    logic       ser_out;
    logic       rx_irq;
    logic       tx_irq;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sio_stat_ctl #(.CLKS_PER_BIT(CPB), .DATA_W(8)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_wr       (stat_wr),
        .stat_wdata    (stat_wdata),
        .stat_rdata    (stat_rdata),
        .txd_wr        (txd_wr),
        .txd_data      (txd_data),
        .rxd_rd        (rxd_rd),
        .rxd_data      (rxd_data),
        .err_clr       (err_clr),
        .nine_bit_mode (nine_bit_mode),
        .parity_on     (parity_on),
        .ser_in        (ser_in),
        .ser_out       (ser_out),
        .rx_irq        (rx_irq),
        .tx_irq        (tx_irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic stat_write(input logic [7:0] v);
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = v;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        rxd_rd = 1'b1;
        @(negedge clk);
        rxd_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic tx_write(input logic [7:0] d);
        @(negedge clk);
        txd_wr = 1'b1;
        txd_data = d;
        @(negedge clk);
        txd_wr = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit has9, input bit b9, input bit stop);
        @(negedge clk);
        ser_in = 1'b0;
        tick(CPB);
        for (int i = 0; i < 8; i++) begin
            ser_in = d[i];
            tick(CPB);
        end
        if (has9) begin
            ser_in = b9;
            tick(CPB);
        end
        ser_in = stop;
        tick(CPB);
        ser_in = 1'b1;
        tick(3 * CPB);
    endtask

    task automatic capture_tx(input bit has9, output logic [10:0] f);
        int guard;
        f = '1;
        guard = 0;
        while (ser_out !== 1'b0 && guard < 40 * CPB) begin
            @(negedge clk);
            guard++;
        end
        tick(CPB / 2);
        f[0] = ser_out;
        for (int i = 1; i <= (has9 ? 10 : 9); i++) begin
            tick(CPB);
            f[i] = ser_out;
        end
    endtask

    initial begin
        logic [10:0] fr;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state, R10 idle line
        check("R1 reset value", {3'b0, stat_rdata}, {3'b0, 8'h22});
        check("R12 irqs after reset", {9'b0, rx_irq, tx_irq}, 11'b0);
        check("R10 idle line high", {10'b0, ser_out}, 11'd1);

        // R12 tx interrupt follows enable
        stat_write(8'h10);
        check("R12 tx_irq enabled", {10'b0, tx_irq}, 11'd1);

        // R2 only bits 4,3,1 writable
        stat_write(8'hFF);
        check("R2 write all ones", {3'b0, stat_rdata}, {3'b0, 8'h3A});
        stat_write(8'h00);
        check("R2 write all zeros", {3'b0, stat_rdata}, {3'b0, 8'h20});
        check("R12 tx_irq disabled", {10'b0, tx_irq}, 11'd0);

        // R3 R4 R5 receive vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] e;
            e = VEC[v];
            pulse_clr();
            pulse_rd();
            nine_bit_mode = e[15];
            parity_on = e[14];
            stat_write({6'b0, e[13], 1'b0});
            send_frame(e[10:3], e[15] | e[14], e[12], e[11]);
            check($sformatf("R3/R4/R5 vec%0d code", v), {9'b0, stat_rdata[7:6]}, {9'b0, e[2:1]});
            check($sformatf("R3 vec%0d bit0", v), {10'b0, stat_rdata[0]}, {10'b0, e[0]});
            if (e[2:1] == 2'b10)
                check($sformatf("R3 vec%0d data", v), {3'b0, rxd_data}, {3'b0, e[10:3]});
        end

        // R4 error does not load data: last accepted byte was 0x07
        check("R4 R5 data kept on error", {3'b0, rxd_data}, {3'b0, 8'h07});
        // R7 read in code 01 has no effect
        pulse_rd();
        check("R7 read ignored in 01", {9'b0, stat_rdata[7:6]}, 11'b01);
        // R8 clear error
        pulse_clr();
        check("R8 clear 01", {9'b0, stat_rdata[7:6]}, 11'b00);

        // R6 overrun
        nine_bit_mode = 1'b0;
        parity_on = 1'b0;
        send_frame(8'h11, 1'b0, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b0, 1'b1);
        check("R6 overrun code", {9'b0, stat_rdata[7:6]}, 11'b11);
        check("R6 overrun keeps data", {3'b0, rxd_data}, {3'b0, 8'h11});
        pulse_rd();
        check("R7 read ignored in 11", {9'b0, stat_rdata[7:6]}, 11'b11);
        pulse_clr();
        check("R8 clear 11", {9'b0, stat_rdata[7:6]}, 11'b10);
        check("R8 data after clear", {3'b0, rxd_data}, {3'b0, 8'h11});
        pulse_rd();
        check("R7 read 10", {9'b0, stat_rdata[7:6]}, 11'b00);

        // R12 receive interrupt
        stat_write(8'h08);
        check("R12 rx_irq idle", {10'b0, rx_irq}, 11'd0);
        send_frame(8'h6E, 1'b0, 1'b0, 1'b1);
        check("R12 rx_irq with data", {10'b0, rx_irq}, 11'd1);
        pulse_rd();
        check("R12 rx_irq after read", {10'b0, rx_irq}, 11'd0);
        send_frame(8'h6F, 1'b0, 1'b0, 0);
        check("R12 rx_irq on error", {10'b0, rx_irq}, 11'd1);
        stat_write(8'h00);
        check("R12 rx_irq masked", {10'b0, rx_irq}, 11'd0);
        pulse_clr();

        // R9 R10 transmit 8-bit frame, second write while busy
        stat_write(8'h12);
        tx_write(8'hA5);
        check("R9 empty clears", {10'b0, stat_rdata[5]}, 11'd0);
        check("R12 tx_irq low while full", {10'b0, tx_irq}, 11'd0);
        tick(1);
        check("R9 empty after load", {10'b0, stat_rdata[5]}, 11'd1);
        tx_write(8'h3C);
        capture_tx(1'b0, fr);
        check("R10 frame 8N1", fr, {2'b11, 8'hA5, 1'b0});
        check("R9 empty held while busy", {10'b0, stat_rdata[5]}, 11'd0);
        capture_tx(1'b0, fr);
        check("R10 second frame", fr, {2'b11, 8'h3C, 1'b0});
        check("R9 empty after second", {10'b0, stat_rdata[5]}, 11'd1);
        tick(2 * CPB);

        // R11 parity on, odd sense
        parity_on = 1'b1;
        stat_write(8'h00);
        tx_write(8'h03);
        capture_tx(1'b1, fr);
        check("R11 odd parity tx", fr, {1'b1, 1'b1, 8'h03, 1'b0});
        tick(2 * CPB);
        // R11 parity on, even sense
        stat_write(8'h02);
        tx_write(8'h07);
        capture_tx(1'b1, fr);
        check("R11 even parity tx", fr, {1'b1, 1'b1, 8'h07, 1'b0});
        tick(2 * CPB);
        // R11 9-bit data, ninth from bit1
        parity_on = 1'b0;
        nine_bit_mode = 1'b1;
        stat_write(8'h00);
        tx_write(8'h5A);
        capture_tx(1'b1, fr);
        check("R11 ninth bit zero", fr, {1'b1, 1'b0, 8'h5A, 1'b0});
        tick(2 * CPB);
        stat_write(8'h02);
        tx_write(8'hC3);
        capture_tx(1'b1, fr);
        check("R11 ninth bit one", fr, {1'b1, 1'b1, 8'hC3, 1'b0});
        tick(3 * CPB);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule